// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides its clock by a programmable 17-bit ratio. The ratio is split into a 13-bit main count (upper bits) and a 4-bit swallow count (lower bits). A synchronous 16/17 modulus prescaler runs under both counters. While the swallow count is non-zero, each prescaler cycle lasts 17 input cycles; afterwards each lasts 16. The main counter closes one division cycle per 16·M + A input cycles. An optional divide-by-two stage can sit ahead of the prescaler. It doubles the overall ratio and the tuning step.

A new ratio is written into a pending register through a one-cycle write strobe. The block checks the ratio when it is written and refuses an illegal one. A pending ratio reaches the counters only when the main counter completes a cycle, so the cycle already in progress always finishes with the ratio it started with. At that boundary the block raises a one-cycle output pulse and a matching boundary strobe. A toggling copy of the output, at half its rate, is provided for test observation.

Top module: `pswallow_divider`

## Requirements
- R1: While and after reset, div_pulse, cyc_stb, ratio_err and tp_half are 0, and the active ratio is the reset ratio 256 (M=16, A=0).
- R2: With de=0, successive div_pulse assertions are exactly 16·M + A clock cycles apart. M is ratio_in[16:4] and A is ratio_in[3:0] of the last accepted write.
- R3: The smallest legal ratio, 240 (M=15, A=0), is accepted and produces a period of 240 cycles. So does a ratio with the largest swallow count, A=15.
- R4: A write whose ratio is below 240, or whose M is less than A, is refused. ratio_err is 1 in the cycle after it, and the division period does not change. A legal write sets ratio_err to 0 in the cycle after it, and ratio_err holds its value when no write occurs.
- R5: A ratio written during a division cycle takes effect only after that cycle ends, so the next period still uses the old ratio. cyc_stb is asserted in exactly the cycles where div_pulse is asserted.
- R6: div_pulse is one clock cycle wide.
- R7: tp_half inverts in the cycle after every div_pulse and is otherwise stable.
- R8: With de=1 (held constant from reset onward), the period is 2·(16·M + A) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| de | input | 1 | Enables the divide-by-two stage ahead of the prescaler; static |
| ratio_we | input | 1 | One-cycle write strobe for ratio_in |
| ratio_in | input | 17 | Requested ratio: M in bits 16..4, A in bits 3..0 |
| div_pulse | output | 1 | One-cycle pulse per completed division cycle |
| cyc_stb | output | 1 | Boundary strobe; pending ratio loaded in this cycle |
| ratio_err | output | 1 | Last write was refused |
| tp_half | output | 1 | Divider output divided by two, for observation |

## Verification
The hardest behaviour to reach from the ports is the hand-over at the cycle boundary. A write has to land while a division cycle is in flight, and the bench must then show that the cycle in flight keeps the old length while the following one takes the new length. The bench first synchronises to an output pulse, then writes the new ratio. It then measures two consecutive pulse intervals with a free-running cycle counter and compares the first with the old ratio and the second with the new one. The same interval measurement shows that a refused ratio leaves the period untouched.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int unsigned DEF_M_W     = 13;
   localparam int unsigned DEF_A_W     = 4;
   localparam int unsigned DEF_MIN     = 240;
   localparam int unsigned DEF_RST     = 256;

   typedef enum logic {
      MOD_LOW  = 1'b0,
      MOD_HIGH = 1'b1
   } mod_e;
endpackage

// File: rtl/psw_ratio_reg.sv
module psw_ratio_reg #(
   parameter int unsigned M_W       = psw_pkg::DEF_M_W,
   parameter int unsigned A_W       = psw_pkg::DEF_A_W,
   parameter int unsigned MIN_RATIO = psw_pkg::DEF_MIN,
   parameter int unsigned RST_RATIO = psw_pkg::DEF_RST
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [M_W+A_W-1:0] ratio_in,
   output logic [M_W-1:0]     pend_m,
   output logic [A_W-1:0]     pend_a,
   output logic               err
);
   localparam int unsigned R_W = M_W + A_W;
   localparam logic [R_W-1:0] RST_VAL = R_W'(RST_RATIO);
   localparam logic [R_W-1:0] MIN_VAL = R_W'(MIN_RATIO);

   logic [M_W-1:0] req_m;
   logic [A_W-1:0] req_a;
   logic           legal;

   assign req_m = ratio_in[R_W-1:A_W];
   assign req_a = ratio_in[A_W-1:0];
   assign legal = (req_m >= M_W'(req_a)) && (ratio_in >= MIN_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_m <= RST_VAL[R_W-1:A_W];
         pend_a <= RST_VAL[A_W-1:0];
         err    <= 1'b0;
      end else if (we) begin
         err <= !legal;
         if (legal) begin
            pend_m <= req_m;
            pend_a <= req_a;
         end
      end
   end
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
   parameter int unsigned A_W     = psw_pkg::DEF_A_W,
   parameter bit          HALF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic de,
   input  logic swallow,
   output logic p_end
);
   import psw_pkg::*;

   localparam int unsigned P_W = A_W + 1;
   localparam logic [P_W-1:0] LAST_LO = P_W'((1 << A_W) - 1);
   localparam logic [P_W-1:0] LAST_HI = P_W'(1 << A_W);

   logic           tick;
   logic [P_W-1:0] cnt;
   logic [P_W-1:0] last;
   mod_e           sel;

   generate
      if (HALF_EN) begin : g_half
         logic half_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  half_q <= 1'b0;
            else if (de) half_q <= !half_q;
         end
         assign tick = de ? half_q : 1'b1;
      end else begin : g_direct
         logic unused_de;
         assign unused_de = de;
         assign tick      = 1'b1;
      end
   endgenerate

   assign sel   = swallow ? MOD_HIGH : MOD_LOW;
   assign last  = (sel == MOD_HIGH) ? LAST_HI : LAST_LO;
   assign p_end = tick && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (tick)  cnt <= p_end ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/psw_counters.sv
module psw_counters #(
   parameter int unsigned M_W       = psw_pkg::DEF_M_W,
   parameter int unsigned A_W       = psw_pkg::DEF_A_W,
   parameter int unsigned RST_RATIO = psw_pkg::DEF_RST
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           p_end,
   input  logic [M_W-1:0] pend_m,
   input  logic [A_W-1:0] pend_a,
   output logic           swallow,
   output logic           div_pulse,
   output logic           cyc_stb
);
   localparam int unsigned R_W = M_W + A_W;
   localparam logic [R_W-1:0] RST_VAL = R_W'(RST_RATIO);

   logic [M_W-1:0] m_cnt;
   logic [A_W-1:0] a_cnt;
   logic           m_last;
   logic           boundary;

   assign swallow  = (a_cnt != '0);
   assign m_last   = (m_cnt == M_W'(1));
   assign boundary = p_end && m_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_cnt     <= RST_VAL[R_W-1:A_W];
         a_cnt     <= RST_VAL[A_W-1:0];
         div_pulse <= 1'b0;
         cyc_stb   <= 1'b0;
      end else begin
         div_pulse <= boundary;
         cyc_stb   <= boundary;
         if (boundary) begin
            m_cnt <= pend_m;
            a_cnt <= pend_a;
         end else if (p_end) begin
            m_cnt <= m_cnt - 1'b1;
            if (swallow) a_cnt <= a_cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
   parameter int unsigned M_W       = psw_pkg::DEF_M_W,
   parameter int unsigned A_W       = psw_pkg::DEF_A_W,
   parameter int unsigned MIN_RATIO = psw_pkg::DEF_MIN,
   parameter int unsigned RST_RATIO = psw_pkg::DEF_RST,
   parameter bit          HALF_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 de,
   input  logic                 ratio_we,
   input  logic [M_W+A_W-1:0]   ratio_in,
   output logic                 div_pulse,
   output logic                 cyc_stb,
   output logic                 ratio_err,
   output logic                 tp_half
);
   localparam int unsigned R_W = M_W + A_W;

   generate
      if (A_W < 1 || M_W < 2) begin : g_bad_width
         $error("pswallow_divider: counter widths too small");
      end
      if (RST_RATIO < MIN_RATIO || RST_RATIO >= (1 << R_W)) begin : g_bad_rst
         $error("pswallow_divider: reset ratio outside legal range");
      end
      if (MIN_RATIO < (1 << A_W) * ((1 << A_W) - 1)) begin : g_bad_min
         $error("pswallow_divider: minimum ratio cannot guarantee M >= A");
      end
   endgenerate

   logic [M_W-1:0] pend_m;
   logic [A_W-1:0] pend_a;
   logic           swallow;
   logic           p_end;

   psw_ratio_reg #(
      .M_W(M_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO), .RST_RATIO(RST_RATIO)
   ) u_ratio (
      .clk(clk), .rst_n(rst_n), .we(ratio_we), .ratio_in(ratio_in),
      .pend_m(pend_m), .pend_a(pend_a), .err(ratio_err)
   );

   psw_prescaler #(
      .A_W(A_W), .HALF_EN(HALF_EN)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .de(de), .swallow(swallow), .p_end(p_end)
   );

   psw_counters #(
      .M_W(M_W), .A_W(A_W), .RST_RATIO(RST_RATIO)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .p_end(p_end), .pend_m(pend_m),
      .pend_a(pend_a), .swallow(swallow), .div_pulse(div_pulse),
      .cyc_stb(cyc_stb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         tp_half <= 1'b0;
      else if (div_pulse) tp_half <= !tp_half;
   end
endmodule

// File: rtl/psw_chk.sv
module psw_chk #(
   parameter int unsigned M_W       = psw_pkg::DEF_M_W,
   parameter int unsigned A_W       = psw_pkg::DEF_A_W,
   parameter int unsigned MIN_RATIO = psw_pkg::DEF_MIN
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ratio_we,
   input logic [M_W+A_W-1:0] ratio_in,
   input logic               div_pulse,
   input logic               cyc_stb,
   input logic               ratio_err,
   input logic               tp_half
);
   localparam int unsigned R_W = M_W + A_W;

   logic        bad_req;
   int unsigned gap;
   logic        seen;

   assign bad_req = (ratio_in[R_W-1:A_W] < M_W'(ratio_in[A_W-1:0])) ||
                    (ratio_in < R_W'(MIN_RATIO));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (div_pulse) begin
         gap  <= 0;
         seen <= 1'b1;
      end else if (gap != 32'hFFFF_FFFF) begin
         gap <= gap + 1;
      end
   end

   // R4
   refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_we && bad_req |=> ratio_err);
   // R4
   accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_we && !bad_req |=> !ratio_err);
   // R4
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ratio_we |=> $stable(ratio_err));
   // R5
   strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse == cyc_stb);
   // R6
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);
   // R7
   tp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> (tp_half != $past(tp_half)));
   // R7
   tp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_pulse |=> $stable(tp_half));
   // R3
   min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse && seen |-> gap >= MIN_RATIO - 1);
endmodule

bind pswallow_divider psw_chk #(
   .M_W(M_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ratio_we(ratio_we), .ratio_in(ratio_in),
   .div_pulse(div_pulse), .cyc_stb(cyc_stb), .ratio_err(ratio_err),
   .tp_half(tp_half)
);

// File: tb/sim_pswallow_divider.sv
`timescale 1ns/1ps
module sim_pswallow_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        de = 1'b0;
   logic        ratio_we = 1'b0;
   logic [16:0] ratio_in = '0;
   logic        div_pulse, cyc_stb, ratio_err, tp_half;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = !clk;
   always @(posedge clk) cyc <= cyc + 1;

   pswallow_divider u0 (
      .clk(clk), .rst_n(rst_n), .de(de), .ratio_we(ratio_we),
      .ratio_in(ratio_in), .div_pulse(div_pulse), .cyc_stb(cyc_stb),
      .ratio_err(ratio_err), .tp_half(tp_half)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic de_val);
      @(negedge clk);
      rst_n = 1'b0;
      de    = de_val;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_ratio(input int v);
      @(negedge clk);
      ratio_we = 1'b1;
      ratio_in = 17'(v);
      @(negedge clk);
      ratio_we = 1'b0;
   endtask

   // waits for a pulse, checks width, strobe and test toggle
   task automatic next_pulse(output int t);
      logic tp_before;
      @(negedge clk);
      while (!div_pulse) @(negedge clk);
      t = cyc;
      tp_before = tp_half;
      chk(cyc_stb == 1'b1, "R5 strobe with pulse", int'(cyc_stb), 1);
      @(negedge clk);
      chk(div_pulse == 1'b0, "R6 pulse width", int'(div_pulse), 0);
      chk(tp_half != tp_before, "R7 tp toggle", int'(tp_half), int'(!tp_before));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(div_pulse == 0 && cyc_stb == 0, "R1 pulses low in reset", int'(div_pulse), 0);
      chk(ratio_err == 0 && tp_half == 0, "R1 flags low in reset", int'(ratio_err), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_default();
      int a, b;
      next_pulse(a);
      next_pulse(b);
      chk(b - a == 256, "R1 reset ratio period", b - a, 256);
   endtask

   task automatic t_reload();
      int a, b, c;
      next_pulse(a);
      write_ratio(300);
      chk(ratio_err == 0, "R4 legal write", int'(ratio_err), 0);
      next_pulse(b);
      chk(b - a == 256, "R5 cycle in flight keeps old ratio", b - a, 256);
      next_pulse(c);
      chk(c - b == 300, "R2 new ratio 300 (M=18 A=12)", c - b, 300);
   endtask

   task automatic t_ratio(input int v, input string req);
      int a, b, c;
      next_pulse(a);
      write_ratio(v);
      next_pulse(b);
      next_pulse(c);
      chk(c - b == v, req, c - b, v);
   endtask

   task automatic t_illegal();
      int a, b, c;
      next_pulse(a);
      write_ratio(239);
      chk(ratio_err == 1, "R4 ratio 239 refused", int'(ratio_err), 1);
      repeat (5) @(negedge clk);
      chk(ratio_err == 1, "R4 error holds", int'(ratio_err), 1);
      next_pulse(b);
      next_pulse(c);
      chk(c - b == 300, "R4 period unchanged after refusal", c - b, 300);
      write_ratio(260);
      chk(ratio_err == 0, "R4 legal write clears error", int'(ratio_err), 0);
   endtask

   task automatic t_half();
      int a, b, c;
      do_reset(1'b1);
      next_pulse(a);
      next_pulse(b);
      chk(b - a == 512, "R8 doubled reset period", b - a, 512);
      write_ratio(250);
      next_pulse(c);
      next_pulse(a);
      chk(a - c == 500, "R8 doubled ratio 250", a - c, 500);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_default();
      t_reload();
      t_ratio(240, "R3 minimum ratio 240");
      t_ratio(271, "R3 swallow count 15 (M=16 A=15)");
      t_ratio(4097, "R2 ratio 4097 (M=256 A=1)");
      t_ratio(300, "R2 ratio 300 restored");
      t_illegal();
      t_half();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule